// File: doc/BRIEF.md
# Keyed Index/Data Watchdog Timer

This block is a watchdog timer with all of its configuration reached through one index port and one data port. Software first writes an index value to choose a register, then reads or writes that register through the data port. Every configuration access is behind a key lock. The lock opens only after the unlock key 0x87 is written to the index port twice with no other index write between them. It closes again when the lock key 0xAA is written to the index port. A page-select register chooses which register page is visible, and the watchdog registers appear only on page 0x08.

On the watchdog page, software can start and stop the timer and choose whether it counts seconds or minutes. It can load or read the 8-bit down-counter. It can also let keyboard or mouse events reload the counter with the value it last wrote. The counter steps down on the tick input that matches the chosen unit. When the counter steps from one to zero while the timer is running, the block gives a single-cycle reset pulse. The counter then holds at zero until it is reloaded.

Top module: `wdp_watchdog`

## Requirements
- R1: After reset the lock is closed, so rdata reads 0xFF. wdt_reset is 0, and the counter, enable, unit, event-reload bits and page register are all 0.
- R2: The lock opens only on a second 0x87 index write that directly follows a first 0x87 index write. Any other index value written after the first 0x87 returns the sequence to its start.
- R3: While the lock is not open, rdata reads 0xFF and data-port writes change no register.
- R4: While the lock is open, an index write of 0xAA closes it and leaves the stored index unchanged. Any other index write while open stores that value as the current index.
- R5: Index 0x07 is the page register, 8 bits, readable and writable on any page. Indices 0x30, 0xF5, 0xF6 and 0xF7 are live only while the page register holds 0x08. Any other index, or any page other than 0x08, reads 0x00 and ignores writes.
- R6: Register 0x30 bit 0 is the run enable. It reads back with all other bits 0.
- R7: Register 0xF5 bit 3 selects the count unit: 0 means seconds (tick_sec), 1 means minutes (tick_min). All other bits read 0.
- R8: Writing register 0xF6 loads the counter and also stores that value as the reload value. Reading 0xF6 returns the live counter.
- R9: While running with a nonzero counter, each pulse of the selected tick lowers the counter by 1. The unselected tick has no effect, and nothing decrements while the timer is stopped.
- R10: A decrement from 1 to 0 raises wdt_reset for exactly one cycle, in the cycle after the tick edge. A counter at zero stays at zero, with no further pulse, until it is reloaded.
- R11: In register 0xF7, bit 6 lets kbd_evt reload the counter from the reload value, and bit 7 does the same for mouse_evt. All other bits read 0.
- R12: In the same cycle, a data write to 0xF6 wins over an event reload, and an event reload wins over a tick decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idx_wr | input | 1 | Index-port write strobe |
| data_wr | input | 1 | Data-port write strobe |
| wdata | input | 8 | Write value for either port |
| tick_sec | input | 1 | One-second tick pulse |
| tick_min | input | 1 | One-minute tick pulse |
| kbd_evt | input | 1 | Keyboard event pulse |
| mouse_evt | input | 1 | Mouse event pulse |
| rdata | output | 8 | Data-port read value for the current index |
| wdt_reset | output | 1 | Single-cycle expiry reset pulse |

## Verification
The hardest state to reach is the half-open lock state followed by a stray index write. From the ports it shows no difference from the fully closed state. The stimulus therefore sweeps every index value other than 0x87 between two key writes. It then proves the lock is still closed, because rdata reads 0xFF. A further 0x87 must then open it, and a read of the page register shows that it did. The expiry edge and the three-way collision between a data write, an event reload and a tick are driven in one cycle each. The effect is then read back through register 0xF6.

// File: rtl/wdp_pkg.sv
package wdp_pkg;
    localparam int unsigned REG_W = 8;

    typedef enum logic [1:0] {
        LK_CLOSED = 2'd0,
        LK_HALF   = 2'd1,
        LK_OPEN   = 2'd2
    } lock_st_e;

    typedef struct packed {
        logic run;
        logic minutes;
        logic kbd_ld;
        logic mse_ld;
    } wd_cfg_t;

    function automatic logic pick_tick(input logic minutes, input logic ts, input logic tm);
        return minutes ? tm : ts;
    endfunction
endpackage

// File: rtl/wdp_keylock.sv
module wdp_keylock #(
    parameter int unsigned DW = wdp_pkg::REG_W,
    parameter logic [DW-1:0] KEY_OPEN  = 8'h87,
    parameter logic [DW-1:0] KEY_CLOSE = 8'hAA
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          idx_wr,
    input  logic [DW-1:0] wdata,
    output logic          open_o,
    output logic [DW-1:0] idx_o
);
    import wdp_pkg::*;

    lock_st_e      st_q;
    logic [DW-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= LK_CLOSED;
            idx_q <= '0;
        end else if (idx_wr) begin
            unique case (st_q)
                LK_CLOSED: st_q <= (wdata == KEY_OPEN) ? LK_HALF : LK_CLOSED;
                LK_HALF:   st_q <= (wdata == KEY_OPEN) ? LK_OPEN : LK_CLOSED;
                LK_OPEN: begin
                    if (wdata == KEY_CLOSE) st_q <= LK_CLOSED;
                    else                    idx_q <= wdata;
                end
                default:   st_q <= LK_CLOSED;
            endcase
        end
    end

    assign open_o = (st_q == LK_OPEN);
    assign idx_o  = idx_q;
endmodule

// File: rtl/wdp_regs.sv
module wdp_regs #(
    parameter int unsigned DW = wdp_pkg::REG_W,
    parameter logic [DW-1:0] IDX_PAGE = 8'h07,
    parameter logic [DW-1:0] PAGE_WD  = 8'h08,
    parameter logic [DW-1:0] IDX_EN   = 8'h30,
    parameter logic [DW-1:0] IDX_UNIT = 8'hF5,
    parameter logic [DW-1:0] IDX_CNT  = 8'hF6,
    parameter logic [DW-1:0] IDX_EVT  = 8'hF7,
    parameter int unsigned BIT_EN   = 0,
    parameter int unsigned BIT_UNIT = 3,
    parameter int unsigned BIT_KBD  = 6,
    parameter int unsigned BIT_MSE  = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             open_i,
    input  logic [DW-1:0]    idx_i,
    input  logic             data_wr,
    input  logic [DW-1:0]    wdata,
    input  logic [DW-1:0]    cnt_i,
    output wdp_pkg::wd_cfg_t cfg_o,
    output logic             cnt_wr_o,
    output logic [DW-1:0]    rdata
);
    import wdp_pkg::*;

    logic [DW-1:0] page_q;
    wd_cfg_t       cfg_q;
    logic          wr_ok;
    logic          wd_sel;

    assign wr_ok  = open_i && data_wr;
    assign wd_sel = (page_q == PAGE_WD);

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
            cfg_q  <= '0;
        end else if (wr_ok) begin
            if (idx_i == IDX_PAGE) page_q <= wdata;
            if (wd_sel) begin
                if (idx_i == IDX_EN)   cfg_q.run     <= wdata[BIT_EN];
                if (idx_i == IDX_UNIT) cfg_q.minutes <= wdata[BIT_UNIT];
                if (idx_i == IDX_EVT) begin
                    cfg_q.kbd_ld <= wdata[BIT_KBD];
                    cfg_q.mse_ld <= wdata[BIT_MSE];
                end
            end
        end
    end

    assign cnt_wr_o = wr_ok && wd_sel && (idx_i == IDX_CNT);
    assign cfg_o    = cfg_q;

    always_comb begin
        rdata = '0;
        if (!open_i) begin
            rdata = '1;
        end else if (idx_i == IDX_PAGE) begin
            rdata = page_q;
        end else if (wd_sel) begin
            if (idx_i == IDX_EN)   rdata[BIT_EN]   = cfg_q.run;
            if (idx_i == IDX_UNIT) rdata[BIT_UNIT] = cfg_q.minutes;
            if (idx_i == IDX_CNT)  rdata           = cnt_i;
            if (idx_i == IDX_EVT) begin
                rdata[BIT_KBD] = cfg_q.kbd_ld;
                rdata[BIT_MSE] = cfg_q.mse_ld;
            end
        end
    end
endmodule

// File: rtl/wdp_timer.sv
module wdp_timer #(
    parameter int unsigned CW = wdp_pkg::REG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  wdp_pkg::wd_cfg_t cfg_i,
    input  logic             cnt_wr,
    input  logic [CW-1:0]    wdata,
    input  logic             tick_sec,
    input  logic             tick_min,
    input  logic             kbd_evt,
    input  logic             mouse_evt,
    output logic [CW-1:0]    cnt_o,
    output logic             ld_any_o,
    output logic             expire_o
);
    import wdp_pkg::*;

    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] reload_q;
    logic          expire_q;
    logic          evt_ld;
    logic          step;

    assign evt_ld = (cfg_i.kbd_ld && kbd_evt) || (cfg_i.mse_ld && mouse_evt);
    assign step   = cfg_i.run && pick_tick(cfg_i.minutes, tick_sec, tick_min) && (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            reload_q <= '0;
            expire_q <= 1'b0;
        end else begin
            expire_q <= 1'b0;
            if (cnt_wr) begin
                cnt_q    <= wdata;
                reload_q <= wdata;
            end else if (evt_ld) begin
                cnt_q <= reload_q;
            end else if (step) begin
                cnt_q    <= cnt_q - ONE;
                expire_q <= (cnt_q == ONE);
            end
        end
    end

    assign cnt_o    = cnt_q;
    assign ld_any_o = cnt_wr || evt_ld;
    assign expire_o = expire_q;
endmodule

// File: rtl/wdp_watchdog.sv
module wdp_watchdog #(
    parameter int unsigned DW = wdp_pkg::REG_W,
    parameter logic [DW-1:0] KEY_OPEN  = 8'h87,
    parameter logic [DW-1:0] KEY_CLOSE = 8'hAA
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          idx_wr,
    input  logic          data_wr,
    input  logic [DW-1:0] wdata,
    input  logic          tick_sec,
    input  logic          tick_min,
    input  logic          kbd_evt,
    input  logic          mouse_evt,
    output logic [DW-1:0] rdata,
    output logic          wdt_reset
);
    import wdp_pkg::*;

    logic          lk_open;
    logic [DW-1:0] idx_q;
    logic [DW-1:0] cnt_q;
    logic          cnt_wr;
    logic          ld_any;
    wd_cfg_t       cfg;

    wdp_keylock #(.DW(DW), .KEY_OPEN(KEY_OPEN), .KEY_CLOSE(KEY_CLOSE)) u_lock (
        .clk(clk), .rst(rst), .idx_wr(idx_wr), .wdata(wdata),
        .open_o(lk_open), .idx_o(idx_q)
    );

    wdp_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst(rst), .open_i(lk_open), .idx_i(idx_q),
        .data_wr(data_wr), .wdata(wdata), .cnt_i(cnt_q),
        .cfg_o(cfg), .cnt_wr_o(cnt_wr), .rdata(rdata)
    );

    wdp_timer #(.CW(DW)) u_timer (
        .clk(clk), .rst(rst), .cfg_i(cfg), .cnt_wr(cnt_wr), .wdata(wdata),
        .tick_sec(tick_sec), .tick_min(tick_min),
        .kbd_evt(kbd_evt), .mouse_evt(mouse_evt),
        .cnt_o(cnt_q), .ld_any_o(ld_any), .expire_o(wdt_reset)
    );
endmodule

// File: rtl/wdp_watchdog_chk.sv
module wdp_watchdog_chk #(
    parameter int unsigned DW = wdp_pkg::REG_W,
    parameter logic [DW-1:0] KEY_OPEN  = 8'h87,
    parameter logic [DW-1:0] KEY_CLOSE = 8'hAA
) (
    input logic          clk,
    input logic          rst,
    input logic          idx_wr,
    input logic [DW-1:0] wdata,
    input logic [DW-1:0] rdata,
    input logic          lk_open,
    input logic [DW-1:0] cnt,
    input logic          ld_any,
    input logic          run,
    input logic          wdt_reset
);
    p_locked_read_r3: assert property (@(posedge clk) disable iff (rst)
        !lk_open |-> rdata == '1);

    p_open_key_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(lk_open) |-> $past(idx_wr && (wdata == KEY_OPEN)));

    p_close_key_r4: assert property (@(posedge clk) disable iff (rst)
        (lk_open && idx_wr && wdata == KEY_CLOSE) |=> !lk_open);

    p_pulse_single_r10: assert property (@(posedge clk) disable iff (rst)
        wdt_reset |=> !wdt_reset);

    p_pulse_cause_r10: assert property (@(posedge clk) disable iff (rst)
        wdt_reset |-> (cnt == '0) && ($past(cnt) == DW'(1)));

    p_zero_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0 && !ld_any) |=> cnt == '0);

    p_unit_step_r9: assert property (@(posedge clk) disable iff (rst)
        !ld_any |=> (cnt == $past(cnt)) || (cnt == $past(cnt) - DW'(1)));

    p_stopped_r9: assert property (@(posedge clk) disable iff (rst)
        (!run && !ld_any) |=> $stable(cnt));
endmodule

bind wdp_watchdog wdp_watchdog_chk #(.DW(DW), .KEY_OPEN(KEY_OPEN), .KEY_CLOSE(KEY_CLOSE)) u_chk (
    .clk(clk), .rst(rst), .idx_wr(idx_wr), .wdata(wdata), .rdata(rdata),
    .lk_open(lk_open), .cnt(cnt_q), .ld_any(ld_any), .run(cfg.run),
    .wdt_reset(wdt_reset)
);

// File: tb/wdp_watchdog_test.sv
module wdp_watchdog_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       idx_wr = 1'b0;
    logic       data_wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       tick_sec = 1'b0;
    logic       tick_min = 1'b0;
    logic       kbd_evt = 1'b0;
    logic       mouse_evt = 1'b0;
    logic [7:0] rdata;
    logic       wdt_reset;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    wdp_watchdog uut (
        .clk(clk), .rst(rst), .idx_wr(idx_wr), .data_wr(data_wr), .wdata(wdata),
        .tick_sec(tick_sec), .tick_min(tick_min), .kbd_evt(kbd_evt),
        .mouse_evt(mouse_evt), .rdata(rdata), .wdt_reset(wdt_reset)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic idx_w(input logic [7:0] v);
        idx_wr = 1'b1; wdata = v;
        @(negedge clk);
        idx_wr = 1'b0;
    endtask

    task automatic dat_w(input logic [7:0] v);
        data_wr = 1'b1; wdata = v;
        @(negedge clk);
        data_wr = 1'b0;
    endtask

    task automatic wreg(input logic [7:0] a, input logic [7:0] v);
        idx_w(a); dat_w(v);
    endtask

    task automatic unlock();
        idx_w(8'h87); idx_w(8'h87);
    endtask

    task automatic tick(input bit minute);
        if (minute) tick_min = 1'b1; else tick_sec = 1'b1;
        @(negedge clk);
        tick_min = 1'b0; tick_sec = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 rdata locked", rdata, 8'hFF);
        chk("R1 wdt_reset", {7'b0, wdt_reset}, 8'h00);
        unlock();
        idx_w(8'h07); chk("R1 page", rdata, 8'h00);
        idx_w(8'h07); dat_w(8'h08);
        idx_w(8'h30); chk("R1 enable", rdata, 8'h00);
        idx_w(8'hF5); chk("R1 unit", rdata, 8'h00);
        idx_w(8'hF6); chk("R1 counter", rdata, 8'h00);
        idx_w(8'hF7); chk("R1 evt", rdata, 8'h00);
        idx_w(8'h07);
        idx_w(8'hAA);
        chk("R4 closed", rdata, 8'hFF);

        // R2 sweep of stray index values between keys
        for (int x = 0; x < 256; x++) begin
            if (x != 8'h87) begin
                idx_w(8'h87);
                idx_w(8'(x));
                idx_w(8'h87);
                chk("R2 stray keeps lock", rdata, 8'hFF);
                idx_w(8'h87);
                idx_w(8'h07);
                chk("R2 opened page read", rdata, 8'h08);
                idx_w(8'hAA);
                chk("R4 relock", rdata, 8'hFF);
            end
        end

        unlock();
        // R5 page register and page gating
        idx_w(8'h07); dat_w(8'h05); chk("R5 page rw", rdata, 8'h05);
        idx_w(8'hF6); chk("R5 off-page read", rdata, 8'h00);
        dat_w(8'h33);
        idx_w(8'h07); dat_w(8'h08);
        idx_w(8'hF6); chk("R5 off-page write ignored", rdata, 8'h00);
        idx_w(8'h55); chk("R5 unused index", rdata, 8'h00);

        // R6 / R7 / R11 bit masks
        wreg(8'h30, 8'hFF); chk("R6 enable mask", rdata, 8'h01);
        wreg(8'h30, 8'hFE); chk("R6 enable clear", rdata, 8'h00);
        wreg(8'hF5, 8'hFF); chk("R7 unit mask", rdata, 8'h08);
        wreg(8'hF5, 8'h00);
        wreg(8'hF7, 8'hFF); chk("R11 evt mask", rdata, 8'hC0);
        wreg(8'hF7, 8'h00);

        // R9 / R10 countdown sweep over both units
        for (int u = 0; u < 2; u++) begin
            wreg(8'hF5, (u != 0) ? 8'h08 : 8'h00);
            wreg(8'h30, 8'h01);
            for (int n = 1; n <= 6; n++) begin
                wreg(8'hF6, 8'(n));
                chk("R8 load", rdata, 8'(n));
                for (int k = 1; k <= n; k++) begin
                    tick(u == 0);
                    chk("R9 wrong tick ignored", rdata, 8'(n - k + 1));
                    tick(u != 0);
                    chk("R9 step", rdata, 8'(n - k));
                    chk("R10 pulse", {7'b0, wdt_reset}, (k == n) ? 8'h01 : 8'h00);
                end
                @(negedge clk);
                chk("R10 single cycle", {7'b0, wdt_reset}, 8'h00);
                tick(u != 0);
                chk("R10 hold zero", rdata, 8'h00);
                chk("R10 no repeat", {7'b0, wdt_reset}, 8'h00);
            end
        end
        wreg(8'hF5, 8'h00);

        // R9 stopped timer
        wreg(8'hF6, 8'h09);
        wreg(8'h30, 8'h00);
        idx_w(8'hF6);
        tick(1'b0);
        chk("R9 stopped", rdata, 8'h09);
        wreg(8'h30, 8'h01);
        idx_w(8'hF6);

        // R11 event reloads
        wreg(8'hF7, 8'h40);
        wreg(8'hF6, 8'h05);
        tick(1'b0); tick(1'b0);
        chk("R11 pre", rdata, 8'h03);
        mouse_evt = 1'b1; @(negedge clk); mouse_evt = 1'b0;
        chk("R11 mouse masked", rdata, 8'h03);
        kbd_evt = 1'b1; @(negedge clk); kbd_evt = 1'b0;
        chk("R11 kbd reload", rdata, 8'h05);
        wreg(8'hF7, 8'h80);
        idx_w(8'hF6);
        tick(1'b0);
        kbd_evt = 1'b1; @(negedge clk); kbd_evt = 1'b0;
        chk("R11 kbd masked", rdata, 8'h04);
        mouse_evt = 1'b1; @(negedge clk); mouse_evt = 1'b0;
        chk("R11 mouse reload", rdata, 8'h05);

        // R12 priority
        wreg(8'hF7, 8'hC0);
        idx_w(8'hF6);
        data_wr = 1'b1; wdata = 8'h20; kbd_evt = 1'b1; tick_sec = 1'b1;
        @(negedge clk);
        data_wr = 1'b0; kbd_evt = 1'b0; tick_sec = 1'b0;
        chk("R12 write wins", rdata, 8'h20);
        tick(1'b0); tick(1'b0);
        kbd_evt = 1'b1; tick_sec = 1'b1;
        @(negedge clk);
        kbd_evt = 1'b0; tick_sec = 1'b0;
        chk("R12 reload beats tick", rdata, 8'h20);

        // R3 locked writes ignored, R4 index kept across lock
        wreg(8'h30, 8'h00);
        idx_w(8'hF6);
        idx_w(8'hAA);
        chk("R3 locked read", rdata, 8'hFF);
        dat_w(8'h11);
        idx_w(8'h87);
        dat_w(8'h12);
        chk("R3 half read", rdata, 8'hFF);
        idx_w(8'h87);
        chk("R3 write ignored", rdata, 8'h20);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule